// File: doc/BRIEF.md
# SPI Serial Memory Command Front End with Write Protection

This block is the slave side of a four-wire serial link that fronts a byte-wide nonvolatile array of 1024 bytes. The array is modelled as registers, and each write is followed by a busy window of fixed length. A host selects the block by pulling chip select low. It then shifts in an 8-bit opcode, a 16-bit address where the opcode needs one, and data. Serial clock idle level may be low or high. The block samples input bits on rising serial-clock edges and drives output bits on falling ones. All serial pins are oversampled by the core clock, so the serial clock must run several times slower than the core clock.

Writes pass several gates before the array changes:
- the write latch must be set;
- the protect pin must be high;
- the target page must lie outside the region chosen by a 3-bit lock code;
- no earlier write may still be busy.

Bytes of a page write are collected in a page buffer and committed together when chip select rises. One special case serves the supply-threshold trim circuit outside this block. When the programming-voltage flag is asserted, a write of 00h to address 0001h raises a one-cycle set request, and a write of 00h to 0003h raises a one-cycle clear request. In both cases the byte is also stored.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Chip select is active low, and SO is driven (so_oe_o high) only while a selected transaction is in progress. If chip select is already low when reset ends, the block ignores all traffic until chip select has gone high and then low again.
- R2: Idle serial clock low and idle serial clock high both work. SI is captured on rising serial-clock edges and SO changes on falling ones. Opcodes, addresses and data travel MSB first.
- R3: Opcode 03h followed by a 16-bit address returns the addressed byte and then the following bytes. Only the low 10 address bits are used, and the read address wraps from 3FFh to 000h.
- R4: Opcode 06h sets the write latch and opcode 04h clears it. Opcode 05h returns a status byte over and over: bit 0 is busy, bit 1 is the write latch, bits 4:2 are the lock code, and bits 7:5 read 0. After reset the status byte is 00h.
- R5: Opcode 02h issued while the write latch is clear leaves the array unchanged.
- R6: Opcode 02h plus an address plus up to 16 data bytes writes consecutive bytes within one 16-byte page. The write is committed when chip select rises. A byte that runs past the page end wraps to the page start, and a later byte overwrites an earlier one at the same location.
- R7: While wp_ni is low, no array or lock-code write takes effect. The write latch clears at the end of every write or status-write transaction, whether the write was committed or refused.
- R8: A committed write sets the busy bit for BUSY_CYCLES core cycles. Write and status-write opcodes received while busy are ignored and leave the write latch unchanged.
- R9: Lock codes select the protected region. 0 protects nothing, 1 the first page, 2 the last page, and 3 the lower half. Codes 4 to 7 each protect one quarter: code 4+q protects quarter q, which starts at address q*256. A write whose page is protected is refused.
- R10: With hv_i high at commit, a committed write starting at 0001h whose first byte is 00h pulses trip_set_o for one cycle. A committed write starting at 0003h whose first byte is 00h pulses trip_clr_o for one cycle. The two pulses never coincide.
- R11: The serial clock may pause for any time inside a transaction, and decoding resumes at the same bit.
- R12: Opcode 01h followed by one data byte loads bits 4:2 of that byte as the lock code, provided the write latch is set and wp_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write protect, active low |
| hv_i | input | 1 | Programming-voltage present flag |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| trip_set_o | output | 1 | One-cycle set-threshold request |
| trip_clr_o | output | 1 | One-cycle clear-threshold request |

## Verification
Some faults only show up later, on an unrelated read. A wrong bit count or wrong phase corrupts the very next byte on SO. A write-latch or busy fault shows up in the next status read. A faulty page column or lock decode is invisible until the affected location is read back, so every write in the bench is followed by a read of the whole page or of the probed byte. Threshold requests are counted from the output pins right after each commit, so a stray or missing pulse is caught within the same transaction.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
  typedef enum logic [2:0] {K_NONE, K_READ, K_RDSR, K_WRITE, K_STAT} kind_e;

  localparam logic [2:0] LK_NONE  = 3'd0;
  localparam logic [2:0] LK_FIRST = 3'd1;
  localparam logic [2:0] LK_LAST  = 3'd2;
  localparam logic [2:0] LK_LOWER = 3'd3;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= '0;
      else         s_q <= {s_q[1:0], d_i[g]};
    end
    assign lvl_o[g]  = s_q[1];
    assign rise_o[g] = s_q[1] & ~s_q[2];
    assign fall_o[g] = ~s_q[1] & s_q[2];
  end
endmodule

// File: rtl/eep_lock_decode.sv
module eep_lock_decode
  import eep_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 4
) (
  input  logic [2:0]    code_i,
  input  logic [AW-1:0] addr_i,
  output logic          locked_o
);
  always_comb begin
    unique case (code_i)
      LK_NONE:  locked_o = 1'b0;
      LK_FIRST: locked_o = (addr_i[AW-1:PW] == '0);
      LK_LAST:  locked_o = (addr_i[AW-1:PW] == '1);
      LK_LOWER: locked_o = ~addr_i[AW-1];
      default:  locked_o = (addr_i[AW-1:AW-2] == code_i[1:0]);
    endcase
  end
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int N = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(N);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_page_array.sv
module eep_page_array #(
  parameter int BYTES = 1024,
  parameter int PAGE  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [$clog2(BYTES)-$clog2(PAGE)-1:0] page_i,
  input  logic [PAGE-1:0]               mask_i,
  input  logic [PAGE-1:0][7:0]          data_i,
  input  logic [$clog2(BYTES)-1:0]      raddr_i,
  output logic [7:0]                    rdata_o
);
  localparam int PW = $clog2(PAGE);
  logic [7:0] mem_q [BYTES];

  // erased cells read as FFh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      for (int c = 0; c < PAGE; c++)
        if (mask_i[c]) mem_q[{page_i, PW'(c)}] <= data_i[c];
    end
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic wp_ni,
  input  logic hv_i,
  output logic so_o,
  output logic so_oe_o,
  output logic trip_set_o,
  output logic trip_clr_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [2:0] lvl, rise, fall;
  spi_edge_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni, .d_i({si_i, sck_i, cs_ni}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );
  logic si_l, ev_sck_r, ev_sck_f, ev_cs_r, ev_cs_f;
  assign si_l     = lvl[2];
  assign ev_sck_r = rise[1];
  assign ev_sck_f = fall[1];
  assign ev_cs_r  = rise[0];
  assign ev_cs_f  = fall[0];
  logic unused_sync;
  assign unused_sync = ^{lvl[1:0], rise[2], fall[2]};

  phase_e phase_q;
  kind_e  kind_q;
  logic [2:0]  bit_q;
  logic [6:0]  sh_q;
  logic        hi_done_q, got_q, wel_q, so_q;
  logic [7:0]  hi_q, out_q, first_q;
  logic [15:0] start16_q;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] col_q;
  logic [2:0]  lock_q, new_lock_q;
  logic [PAGE_BYTES-1:0]      mask_q;
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic        trip_set_q, trip_clr_q;

  logic [7:0]  rx_byte, rd_data, status;
  logic [15:0] new_addr16;
  logic [AW-1:0] rd_addr;
  logic last_bit, busy, locked, wr_end, stat_end, commit, stat_commit;

  assign rx_byte    = {sh_q, si_l};
  assign last_bit   = (bit_q == 3'd7);
  assign new_addr16 = {hi_q, rx_byte};
  assign rd_addr    = (phase_q == PH_ADDR) ? new_addr16[AW-1:0] : addr_q + 1'b1;
  assign status     = {3'b000, lock_q, wel_q, busy};

  eep_lock_decode #(.AW(AW), .PW(PW)) u_lock (
    .code_i(lock_q), .addr_i(addr_q), .locked_o(locked)
  );

  assign wr_end      = ev_cs_r && kind_q == K_WRITE && (phase_q == PH_ADDR || phase_q == PH_DATA);
  assign stat_end    = ev_cs_r && kind_q == K_STAT && phase_q == PH_DATA;
  assign commit      = wr_end && got_q && wel_q && wp_ni && !locked;
  assign stat_commit = stat_end && got_q && wel_q && wp_ni;

  eep_busy_timer #(.N(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(commit | stat_commit), .busy_o(busy)
  );

  eep_page_array #(.BYTES(MEM_BYTES), .PAGE(PAGE_BYTES)) u_array (
    .clk_i, .rst_ni, .we_i(commit), .page_i(addr_q[AW-1:PW]),
    .mask_i(mask_q), .data_i(buf_q), .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;  kind_q <= K_NONE;  bit_q <= '0;  sh_q <= '0;
      hi_done_q <= 1'b0;   got_q <= 1'b0;     wel_q <= 1'b0; so_q <= 1'b0;
      hi_q <= '0;  out_q <= '0;  first_q <= '0;  start16_q <= '0;
      addr_q <= '0;  col_q <= '0;  lock_q <= LK_NONE;  new_lock_q <= LK_NONE;
      mask_q <= '0;  buf_q <= '0;  trip_set_q <= 1'b0;  trip_clr_q <= 1'b0;
    end else begin
      trip_set_q <= 1'b0;
      trip_clr_q <= 1'b0;
      if (ev_cs_f) begin
        phase_q <= PH_CMD;  kind_q <= K_NONE;  bit_q <= '0;
        hi_done_q <= 1'b0;  got_q <= 1'b0;     mask_q <= '0;
      end else if (ev_cs_r) begin
        phase_q <= PH_IDLE;
        if (wr_end || stat_end) wel_q <= 1'b0;
        if (stat_commit) lock_q <= new_lock_q;
        if (commit && hv_i && first_q == 8'h00) begin
          trip_set_q <= (start16_q == 16'h0001);
          trip_clr_q <= (start16_q == 16'h0003);
        end
      end else if (ev_sck_r && phase_q != PH_IDLE && phase_q != PH_SKIP) begin
        sh_q  <= rx_byte[6:0];
        bit_q <= bit_q + 1'b1;
        if (last_bit) begin
          unique case (phase_q)
            PH_CMD: begin
              phase_q <= PH_SKIP;
              unique case (rx_byte)
                OP_WREN:  wel_q <= 1'b1;
                OP_WRDI:  wel_q <= 1'b0;
                OP_RDSR:  begin kind_q <= K_RDSR; phase_q <= PH_DATA; out_q <= status; end
                OP_READ:  begin kind_q <= K_READ; phase_q <= PH_ADDR; end
                OP_WRITE: if (!busy) begin kind_q <= K_WRITE; phase_q <= PH_ADDR; end
                OP_WRSR:  if (!busy) begin kind_q <= K_STAT;  phase_q <= PH_DATA; end
                default:  ;
              endcase
            end
            PH_ADDR: begin
              if (!hi_done_q) begin
                hi_q <= rx_byte;  hi_done_q <= 1'b1;
              end else begin
                start16_q <= new_addr16;
                addr_q    <= new_addr16[AW-1:0];
                col_q     <= new_addr16[PW-1:0];
                out_q     <= rd_data;
                phase_q   <= PH_DATA;
              end
            end
            PH_DATA: begin
              unique case (kind_q)
                K_READ:  begin addr_q <= addr_q + 1'b1; out_q <= rd_data; end
                K_RDSR:  out_q <= status;
                K_WRITE: begin
                  buf_q[col_q]  <= rx_byte;
                  mask_q[col_q] <= 1'b1;
                  col_q         <= col_q + 1'b1;  // wraps inside the page
                  if (!got_q) first_q <= rx_byte;
                  got_q <= 1'b1;
                end
                K_STAT:  begin new_lock_q <= rx_byte[4:2]; got_q <= 1'b1; end
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end else if (ev_sck_f && phase_q == PH_DATA && (kind_q == K_READ || kind_q == K_RDSR)) begin
        so_q <= out_q[~bit_q];
      end
    end
  end

  assign so_o       = so_q;
  assign so_oe_o    = (phase_q != PH_IDLE);
  assign trip_set_o = trip_set_q;
  assign trip_clr_o = trip_clr_q;
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic wp_ni,
  input logic so_oe_o,
  input logic trip_set_o,
  input logic trip_clr_o,
  input logic busy,
  input logic commit,
  input logic wel
);
  // R1
  so_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !so_oe_o);
  // R7
  wp_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> wp_ni);
  // R7
  wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !wel);
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);
  // R8
  no_busy_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !busy);
  // R10
  trip_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trip_set_o && trip_clr_o));
  // R10
  trip_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_set_o || trip_clr_o) |=> !(trip_set_o || trip_clr_o));
endmodule

bind spi_eeprom_ctrl eep_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wp_ni(wp_ni),
  .so_oe_o(so_oe_o), .trip_set_o(trip_set_o), .trip_clr_o(trip_clr_o),
  .busy(busy), .commit(commit), .wel(wel_q)
);

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;
  localparam int BUSY = 600;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hv = 1'b0;
  logic so, so_oe, t_set, t_clr;
  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(.MEM_BYTES(1024), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .wp_ni(wp_n), .hv_i(hv), .so_o(so), .so_oe_o(so_oe),
    .trip_set_o(t_set), .trip_clr_o(t_clr)
  );

  int n_chk = 0, n_bad = 0, n_set = 0, n_clr = 0;
  logic mode3 = 1'b0;
  logic [7:0] ref_mem [1024];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic [7:0] junk, st;
  int lock_ref = 0;

  always @(posedge clk) begin
    if (t_set) n_set++;
    if (t_clr) n_clr++;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; wclk(8);
  endtask

  task automatic desel();
    wclk(4); cs_n = 1'b1; wclk(8);
  endtask

  task automatic set_mode(input logic m);
    mode3 = m; sck = m; wclk(4);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int stall = 0);
    for (int i = 7; i >= 0; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      wclk(HALF);
      rx[i] = so;
      sck = 1'b1;
      wclk(HALF);
      if (i == 4) wclk(stall);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); xbyte(op, junk); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); xbyte(8'h05, junk); xbyte(8'h00, s); desel();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    sel(); xbyte(8'h02, junk); xbyte(a[15:8], junk); xbyte(a[7:0], junk);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], junk);
    desel();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    sel(); xbyte(8'h03, junk); xbyte(a[15:8], junk); xbyte(a[7:0], junk);
    for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel(); xbyte(8'h01, junk); xbyte(v, junk); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    check("R8 busy never cleared", 1, 0);
  endtask

  function automatic logic locked_ref(input int code, input int a);
    case (code)
      0: return 1'b0;
      1: return (a / 16) == 0;
      2: return (a / 16) == 63;
      3: return a < 512;
      default: return (a / 256) == code - 4;
    endcase
  endfunction

  // reference write: page wrap, latch and region rules
  task automatic ref_write(input int a, input int n, input logic ok);
    if (ok && !locked_ref(lock_ref, a % 1024))
      for (int i = 0; i < n; i++)
        ref_mem[(a % 1024) - (a % 16) + ((a % 16 + i) % 16)] = wbuf[i];
  endtask

  task automatic full_write(input int a, input int n);
    cmd1(8'h06); wr(16'(a), n); ref_write(a, n, wp_n); wait_ready();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
    wclk(5);
    check("R1 oe in reset", {31'd0, so_oe}, 0);
    rst_n = 1'b1; wclk(5);
    // R1: select already low at reset release, opcodes must be ignored
    xbyte(8'h06, junk); xbyte(8'h05, junk);
    check("R1 no edge oe", {31'd0, so_oe}, 0);
    cs_n = 1'b1; wclk(8);
    check("R1 deselected oe", {31'd0, so_oe}, 0);
    rdsr(st); check("R4 reset status", st, 8'h00);

    cmd1(8'h06); rdsr(st); check("R4 latch set", st, 8'h02);
    cmd1(8'h04); rdsr(st); check("R4 latch clear", st, 8'h00);

    // R5
    wbuf[0] = 8'hA5; wr(16'h0010, 1);
    rd(16'h0010, 1); check("R5 unlatched write", rbuf[0], 8'hFF);
    rdsr(st); check("R5 no busy", st, 8'h00);

    // R6 page writes with start offsets and wrap
    for (int s = 0; s < 16; s += 5) begin
      int a = (5 + s) * 16 + s;
      int n = (s == 0) ? 16 : 16 + s;
      for (int i = 0; i < n; i++) wbuf[i] = 8'(s * 16 + i * 7 + 1);
      cmd1(8'h06); wr(16'(a), n); ref_write(a, n, 1'b1);
      rdsr(st); check("R8 busy after write", st, 8'h01);
      wait_ready();
      rdsr(st); check("R7 latch cleared after commit", st, 8'h00);
      rd(16'(a - s), 16);
      for (int i = 0; i < 16; i++) check("R6 page content", rbuf[i], ref_mem[a - s + i]);
    end

    // R8 writes ignored while busy, latch unchanged
    wbuf[0] = 8'h3C; cmd1(8'h06); wr(16'h0200, 1); ref_write(16'h0200, 1, 1'b1);
    wbuf[0] = 8'h77; cmd1(8'h06); wr(16'h0210, 1);
    rdsr(st); check("R8 busy latch kept", st, 8'h03);
    wait_ready(); cmd1(8'h04);
    rd(16'h0210, 1); check("R8 ignored write", rbuf[0], 8'hFF);
    rd(16'h0200, 1); check("R8 first write", rbuf[0], 8'h3C);

    // R7 protect pin
    wp_n = 1'b0;
    wbuf[0] = 8'h11; cmd1(8'h06); wr(16'h0300, 1);
    rdsr(st); check("R7 refused clears latch", st, 8'h00);
    rd(16'h0300, 1); check("R7 protected array", rbuf[0], 8'hFF);
    cmd1(8'h06); wrsr(8'h04);
    rdsr(st); check("R7 protected lock", st, 8'h00);
    wp_n = 1'b1;

    // R3 wrap read, R2 idle-high mode
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; full_write(16'h03FE, 2);
    wbuf[0] = 8'hCC; wbuf[1] = 8'hDD; full_write(16'h0000, 2);
    set_mode(1'b1);
    rd(16'h03FE, 4);
    check("R3 R2 wrap0", rbuf[0], 8'hAA); check("R3 R2 wrap1", rbuf[1], 8'hBB);
    check("R3 R2 wrap2", rbuf[2], 8'hCC); check("R3 R2 wrap3", rbuf[3], 8'hDD);
    rdsr(st); check("R2 status idle high", st, 8'h00);
    set_mode(1'b0);

    // R11 pauses inside address and data bytes
    sel(); xbyte(8'h03, junk); xbyte(8'h03, junk, 300); xbyte(8'hFE, junk);
    xbyte(8'h00, rbuf[0], 250); xbyte(8'h00, rbuf[1]); desel();
    check("R11 paused read0", rbuf[0], 8'hAA);
    check("R11 paused read1", rbuf[1], 8'hBB);

    // R9 / R12 lock sweep
    for (int code = 0; code < 8; code++) begin
      cmd1(8'h06); wrsr(8'(code << 2)); wait_ready();
      lock_ref = code;
      rdsr(st); check("R12 lock code", st, 8'(code << 2));
      for (int k = 0; k < 6; k++) begin
        int pg = (k == 0) ? 0 : (k == 1) ? 15 : (k == 2) ? 16 : (k == 3) ? 32 : (k == 4) ? 48 : 63;
        int a = pg * 16 + 8;
        wbuf[0] = 8'(code * 16 + k + 8'h40);
        full_write(a, 1);
        rd(16'(a), 1);
        check("R9 lock region", rbuf[0], ref_mem[a]);
      end
    end
    cmd1(8'h06); wrsr(8'h00); wait_ready(); lock_ref = 0;

    // R10 threshold requests
    hv = 1'b1;
    wbuf[0] = 8'h00; full_write(16'h0001, 1);
    check("R10 set pulse", n_set, 1); check("R10 no clr", n_clr, 0);
    rd(16'h0001, 1); check("R10 byte stored", rbuf[0], 8'h00);
    full_write(16'h0003, 1);
    check("R10 clr pulse", n_clr, 1); check("R10 set unchanged", n_set, 1);
    wbuf[0] = 8'h01; full_write(16'h0001, 1);
    check("R10 nonzero data", n_set, 1);
    wbuf[0] = 8'h00; full_write(16'h0401, 1);
    check("R10 aliased address", n_set, 1);
    hv = 1'b0;
    full_write(16'h0003, 1);
    check("R10 no flag", n_clr, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule